// File: doc/BRIEF.md
# Synchronous Serial Receive Port

This block receives one word over a clocked serial link and passes it to software through a small register interface. Software first sets a configuration: an operation code, a word length of 8 or 16 bits, MSB-first or LSB-first order, a clock polarity type, and whether the shift clock comes from the port itself or from outside. It then sets a start bit. The port shifts in exactly one word from the serial data input. When the last bit arrives, the port stores the word in a readable data register and pulses an interrupt for one cycle. The start bit then returns to 0 by itself.

As a master, the port makes the shift clock by dividing the system clock and drives it on its clock output. As a slave, it passes an incoming shift clock through a synchronizer and detects its edges in the system clock domain. The serial data output stays high for as long as the operation code selects receive. Software can abort a transfer by writing 0 to the start bit while the transfer runs.

Top module: `ssrx_port`

## Requirements
- R1: After reset the start bit, configuration, divider, data register and interrupt all read 0. The master clock output idles high and the serial output is low.
- R2: The control register sits at address 0: bit 0 is start, bits 2:1 are the operation code, bit 3 selects 16-bit length, bit 4 selects LSB first, bit 5 is the clock type, and bit 6 selects the external clock. A control write with start=1 and code 2'b01 (receive) begins a transfer, and start then reads 1. A start with any other code leaves start at 0.
- R3: When the last bit of a transfer is captured, three things happen in the same cycle: the received word goes to the data register (address 2), irq is high for exactly one cycle, and the start bit reads 0.
- R4: Bit 3 selects a 16-bit transfer when 1 and an 8-bit transfer when 0.
- R5: Bit 4 selects LSB-first reception when 1 and MSB-first reception when 0. In either order, the data register holds the word as the sender meant it.
- R6: With bit 6 = 0 the port is master: sck_oe is 1, and sck_out toggles every DIV+1 system cycles while a transfer runs. DIV is written at address 1. When no transfer runs, sck_out holds the idle level of the clock type.
- R7: With bit 6 = 1 the port is slave: sck_oe is 0, and sck_in and sin pass through a synchronizer before a sample edge is detected.
- R8: Clock type 0 idles high and samples on the rising edge. Clock type 1 idles low and samples on the falling edge.
- R9: sout is 1 while the operation code is receive, and 0 for any other code.
- R10: After an 8-bit transfer, bits 15:8 of the data register read 0.
- R11: A control write with start=0 during a transfer aborts it: no irq, the data register keeps its old value, and start reads 0. This holds even when the abort lands in the same cycle as completion.
- R12: While a transfer runs, writes to the divider and to the configuration bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 divider, 2 data) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| sin | input | 1 | Serial data input |
| sck_in | input | 1 | External shift clock (slave) |
| sck_out | output | 1 | Generated shift clock (master) |
| sck_oe | output | 1 | High when sck_out should drive the clock pin |
| sout | output | 1 | Serial data output, held high in receive mode |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Completion and a software abort can land on the same clock edge: the last sample edge clears start and commits the word, while a control write with start=0 tries to cancel the transfer. The bench drives the slave clock itself. It repeats an 8-bit transfer and moves the abort write one cycle later each time, across the window around the final edge, so the abort is sure to meet completion at some point in the sweep. Each run is judged for atomicity: either irq fired and the data register holds the new word, or neither happened and the old word stays. Both outcomes must occur somewhere in the sweep.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;

   typedef enum logic [1:0] {
      OP_OFF = 2'b00,
      OP_RX  = 2'b01,
      OP_TX  = 2'b10,
      OP_RSV = 2'b11
   } op_e;

   typedef struct packed {
      logic ext_clk;
      logic ck_type;
      logic lsb_first;
      logic len16;
      op_e  op;
   } cfg_t;

   localparam int unsigned CFG_W     = $bits(cfg_t);
   localparam logic [1:0]  ADDR_CTRL = 2'd0;
   localparam logic [1:0]  ADDR_DIV  = 2'd1;
   localparam logic [1:0]  ADDR_DATA = 2'd2;

endpackage

// File: rtl/ssrx_mclk.sv
module ssrx_mclk #(
   parameter int unsigned DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             idle_lvl,
   input  logic [DIV_W-1:0] div,
   output logic             sck,
   output logic             evt
);

   logic [DIV_W-1:0] cnt_q;
   logic             sck_q;
   logic             wrap;

   assign wrap = (cnt_q == div);
   // The sample edge is the toggle that returns the clock to its idle level.
   assign evt  = run && wrap && (sck_q != idle_lvl);
   assign sck  = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (!run) begin
         cnt_q <= '0;
         sck_q <= idle_lvl;
      end else if (wrap) begin
         cnt_q <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && $past(!run) && $stable(idle_lvl)) |-> (sck == idle_lvl));

endmodule

// File: rtl/ssrx_slave_edge.sv
module ssrx_slave_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic samp_lvl,
   input  logic sck_in,
   input  logic sin,
   output logic evt,
   output logic sin_s
);

   logic [STAGES-1:0] sck_sy;
   logic [STAGES-1:0] sin_sy;
   logic              sck_prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_sy[0] <= 1'b0;
               sin_sy[0] <= 1'b0;
            end else begin
               sck_sy[0] <= sck_in;
               sin_sy[0] <= sin;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_sy[i] <= 1'b0;
               sin_sy[i] <= 1'b0;
            end else begin
               sck_sy[i] <= sck_sy[i-1];
               sin_sy[i] <= sin_sy[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_sy[STAGES-1];
   end

   assign evt   = run && (sck_sy[STAGES-1] == samp_lvl) && (sck_prev != samp_lvl);
   assign sin_s = sin_sy[STAGES-1];

endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift #(
   parameter int unsigned SHORT_LEN = 8,
   parameter int unsigned LONG_LEN  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                evt,
   input  logic                bit_in,
   input  logic                len16,
   input  logic                lsb_first,
   output logic                done,
   output logic [LONG_LEN-1:0] word
);

   localparam int unsigned CNT_W = $clog2(LONG_LEN);
   localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SHORT_LEN - 1);
   localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LONG_LEN - 1);

   logic [LONG_LEN-1:0] sh_q;
   logic [LONG_LEN-1:0] nxt;
   logic [CNT_W-1:0]    cnt_q;
   logic [CNT_W-1:0]    last;

   assign last = len16 ? LAST_L : LAST_S;

   always_comb begin
      nxt = sh_q;
      if (!lsb_first) begin
         nxt = {sh_q[LONG_LEN-2:0], bit_in};
      end else if (len16) begin
         nxt = {bit_in, sh_q[LONG_LEN-1:1]};
      end else begin
         nxt[SHORT_LEN-1:0] = {bit_in, sh_q[SHORT_LEN-1:1]};
      end
   end

   assign done = evt && (cnt_q == last);
   assign word = len16 ? nxt : {{(LONG_LEN-SHORT_LEN){1'b0}}, nxt[SHORT_LEN-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (!run) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (evt) begin
         sh_q  <= nxt;
         cnt_q <= done ? '0 : cnt_q + 1'b1;
      end
   end

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= last));

endmodule

// File: rtl/ssrx_port.sv
module ssrx_port
   import ssrx_pkg::*;
#(
   parameter int unsigned SHORT_LEN   = 8,
   parameter int unsigned LONG_LEN    = 16,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [1:0]          reg_addr,
   input  logic [LONG_LEN-1:0] reg_wdata,
   output logic [LONG_LEN-1:0] reg_rdata,
   input  logic                sin,
   input  logic                sck_in,
   output logic                sck_out,
   output logic                sck_oe,
   output logic                sout,
   output logic                irq
);

   localparam int unsigned CTRL_W = CFG_W + 1;

   if (SHORT_LEN == 0 || SHORT_LEN >= LONG_LEN) begin : g_bad_len
      $error("SHORT_LEN must be nonzero and below LONG_LEN");
   end
   if (DIV_W > LONG_LEN || CTRL_W > LONG_LEN) begin : g_bad_w
      $error("register fields exceed the register width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   cfg_t                cfg_q;
   cfg_t                cfg_wr;
   logic                go_q;
   logic                irq_q;
   logic [DIV_W-1:0]    div_q;
   logic [LONG_LEN-1:0] data_q;
   logic                ctrl_wr;
   logic                div_wr;
   logic                abort;
   logic                m_evt;
   logic                s_evt;
   logic                s_bit;
   logic                evt;
   logic                bit_in;
   logic                done;
   logic [LONG_LEN-1:0] word;
   logic                wdata_unused;

   assign cfg_wr  = cfg_t'(reg_wdata[CTRL_W-1:1]);
   assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
   assign div_wr  = reg_wr && (reg_addr == ADDR_DIV);
   assign abort   = ctrl_wr && go_q && !reg_wdata[0];
   assign wdata_unused = ^reg_wdata[LONG_LEN-1:CTRL_W];

   ssrx_mclk #(.DIV_W(DIV_W)) u_mclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (go_q && !cfg_q.ext_clk),
      .idle_lvl (!cfg_q.ck_type),
      .div      (div_q),
      .sck      (sck_out),
      .evt      (m_evt)
   );

   ssrx_slave_edge #(.STAGES(SYNC_STAGES)) u_sedge (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (go_q && cfg_q.ext_clk),
      .samp_lvl (!cfg_q.ck_type),
      .sck_in   (sck_in),
      .sin      (sin),
      .evt      (s_evt),
      .sin_s    (s_bit)
   );

   assign evt    = cfg_q.ext_clk ? s_evt : m_evt;
   assign bit_in = cfg_q.ext_clk ? s_bit : sin;

   ssrx_shift #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (go_q),
      .evt       (evt),
      .bit_in    (bit_in),
      .len16     (cfg_q.len16),
      .lsb_first (cfg_q.lsb_first),
      .done      (done),
      .word      (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         go_q   <= 1'b0;
         irq_q  <= 1'b0;
         div_q  <= '0;
         data_q <= '0;
      end else begin
         irq_q <= 1'b0;
         if (ctrl_wr && !go_q) begin
            cfg_q <= cfg_wr;
            go_q  <= reg_wdata[0] && (cfg_wr.op == OP_RX);
         end else if (abort) begin
            go_q <= 1'b0;
         end else if (done) begin
            go_q   <= 1'b0;
            irq_q  <= 1'b1;
            data_q <= word;
         end
         if (div_wr && !go_q) begin
            div_q <= reg_wdata[DIV_W-1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: reg_rdata[CTRL_W-1:0] = {cfg_q, go_q};
         ADDR_DIV:  reg_rdata[DIV_W-1:0]  = div_q;
         ADDR_DATA: reg_rdata             = data_q;
         default:   reg_rdata             = '0;
      endcase
   end

   assign sck_oe = !cfg_q.ext_clk;
   assign sout   = (cfg_q.op == OP_RX);
   assign irq    = irq_q;

   p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   p_irq_go_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !go_q);
   p_irq_rx_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> sout);
   p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !cfg_q.len16) |-> (data_q[LONG_LEN-1:SHORT_LEN] == '0));
   p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!irq && $stable(data_q)));
   p_busy_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (go_q && $past(go_q)) |-> ($stable(cfg_q) && $stable(div_q)));

endmodule

// File: tb/ssrx_port_tb.sv
module ssrx_port_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        sin = 1'b0;
   logic        sck_in = 1'b1;
   logic        sck_out;
   logic        sck_oe;
   logic        sout;
   logic        irq;

   int total = 0;
   int fails = 0;
   int cycles = 0;
   int irq_count = 0;
   logic [15:0] exp_data = 16'h0;

   logic        m_active = 1'b0;
   logic        m_idle = 1'b1;
   logic [15:0] m_word = 16'h0;
   int          m_len = 8;
   logic        m_lsbf = 1'b0;
   int          m_k = 0;

   always #5 clk = ~clk;

   ssrx_port u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .sin       (sin),
      .sck_in    (sck_in),
      .sck_out   (sck_out),
      .sck_oe    (sck_oe),
      .sout      (sout),
      .irq       (irq)
   );

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (irq) irq_count <= irq_count + 1;
      if (cycles == 150000) begin
         total = total + 1;
         fails = fails + 1;
         $display("FAIL watchdog: run hung act=%0d exp=<150000", cycles);
         finish_run();
      end
   end

   // Master-mode sender: put the next bit out as the clock leaves its idle level.
   always @(sck_out) begin
      if (m_active && sck_out != m_idle) begin
         if (m_k < m_len) sin = m_word[m_lsbf ? m_k : (m_len - 1 - m_k)];
         else             sin = 1'b0;
         m_k = m_k + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [15:0] ctl(input logic go, input logic [1:0] op, input logic len16,
                                       input logic lsbf, input logic ckt, input logic ext);
      return {9'b0, ext, ckt, lsbf, len16, op, go};
   endfunction

   task automatic t_reset();
      logic [15:0] d;
      rd(2'd0, d); chk("R1 ctrl after reset", d, 16'h0);
      rd(2'd1, d); chk("R1 div after reset", d, 16'h0);
      rd(2'd2, d); chk("R1 data after reset", d, 16'h0);
      chk("R1 irq after reset", irq, 1'b0);
      chk("R1 sck_out idle high after reset", sck_out, 1'b1);
      chk("R1 sout low after reset", sout, 1'b0);
   endtask

   task automatic t_mode_gate();
      logic [15:0] d;
      int base;
      base = irq_count;
      wr(2'd0, ctl(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0));
      rd(2'd0, d); chk("R2 start ignored with non-receive code", d[0], 1'b0);
      chk("R9 sout low for non-receive code", sout, 1'b0);
      repeat (20) @(negedge clk);
      chk("R2 no transfer without receive code", irq_count, base);
      wr(2'd0, ctl(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0));
      chk("R9 sout high in receive code", sout, 1'b1);
   endtask

   task automatic t_master(input string nm, input logic len16, input logic lsbf,
                           input logic ckt, input logic [15:0] w, input logic [7:0] div);
      logic [15:0] d;
      logic [15:0] ew;
      int base, n;
      bit seen;
      wr(2'd1, {8'h0, div});
      wr(2'd0, ctl(1'b0, 2'b01, len16, lsbf, ckt, 1'b0));
      @(negedge clk);
      chk({"R8 idle level ", nm}, sck_out, !ckt);
      chk({"R6 master drives clock ", nm}, sck_oe, 1'b1);
      m_idle = !ckt; m_word = w; m_len = len16 ? 16 : 8; m_lsbf = lsbf; m_k = 0;
      m_active = 1'b1;
      base = irq_count;
      wr(2'd0, ctl(1'b1, 2'b01, len16, lsbf, ckt, 1'b0));
      rd(2'd0, d); chk({"R2 start reads 1 ", nm}, d[0], 1'b1);
      n = 0;
      while (sck_out == m_idle && n < 1000) begin @(negedge clk); n++; end
      n = 0;
      while (sck_out != m_idle && n < 1000) begin @(negedge clk); n++; end
      chk({"R6 half period ", nm}, n, div + 1);
      seen = 0;
      for (int i = 0; i < 5000 && !seen; i++) begin
         @(negedge clk);
         if (irq) seen = 1;
      end
      ew = len16 ? w : {8'h0, w[7:0]};
      chk({"R3 irq raised ", nm}, seen, 1'b1);
      rd(2'd2, d); chk({"R3 R4 R5 R10 data ", nm}, d, ew);
      rd(2'd0, d); chk({"R3 start cleared with irq ", nm}, d[0], 1'b0);
      @(negedge clk);
      chk({"R3 irq lasts one cycle ", nm}, irq, 1'b0);
      chk({"R3 single irq ", nm}, irq_count, base + 1);
      m_active = 1'b0;
      exp_data = ew;
   endtask

   task automatic slave_bit(input logic b, input logic idle, input int h);
      @(negedge clk);
      sin = b; sck_in = !idle;
      repeat (h) @(negedge clk);
      sck_in = idle;
      repeat (h) @(negedge clk);
   endtask

   task automatic t_slave(input string nm, input logic len16, input logic lsbf,
                          input logic ckt, input logic [15:0] w);
      logic [15:0] d;
      logic [15:0] ew;
      int base, len;
      len = len16 ? 16 : 8;
      sck_in = !ckt;
      wr(2'd0, ctl(1'b0, 2'b01, len16, lsbf, ckt, 1'b1));
      chk({"R7 slave releases clock ", nm}, sck_oe, 1'b0);
      repeat (4) @(negedge clk);
      base = irq_count;
      wr(2'd0, ctl(1'b1, 2'b01, len16, lsbf, ckt, 1'b1));
      for (int k = 0; k < len; k++)
         slave_bit(w[lsbf ? k : (len - 1 - k)], !ckt, 6);
      ew = len16 ? w : {8'h0, w[7:0]};
      chk({"R7 R8 irq count ", nm}, irq_count, base + 1);
      rd(2'd2, d); chk({"R7 R4 R5 R10 data ", nm}, d, ew);
      rd(2'd0, d); chk({"R3 start cleared ", nm}, d[0], 1'b0);
      exp_data = ew;
   endtask

   task automatic t_busy_lock();
      logic [15:0] d;
      m_idle = 1'b1; m_word = 16'h00C3; m_len = 8; m_lsbf = 1'b0; m_k = 0;
      wr(2'd1, 16'h0002);
      wr(2'd0, ctl(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0));
      @(negedge clk);
      m_active = 1'b1;
      wr(2'd0, ctl(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0));
      wr(2'd0, ctl(1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1));
      wr(2'd1, 16'h0009);
      rd(2'd0, d); chk("R12 config kept while busy", d, ctl(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0));
      rd(2'd1, d); chk("R12 divider kept while busy", d, 16'h0002);
      for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
      rd(2'd2, d); chk("R12 transfer ends with original setup", d, 16'h00C3);
      m_active = 1'b0;
      exp_data = 16'h00C3;
   endtask

   task automatic t_abort_master();
      logic [15:0] d;
      int base;
      m_idle = 1'b1; m_word = 16'h5A5A; m_len = 16; m_lsbf = 1'b0; m_k = 0;
      wr(2'd1, 16'h0004);
      wr(2'd0, ctl(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0));
      @(negedge clk);
      m_active = 1'b1;
      base = irq_count;
      wr(2'd0, ctl(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0));
      repeat (40) @(negedge clk);
      wr(2'd0, ctl(1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0));
      rd(2'd0, d); chk("R11 abort clears start", d[0], 1'b0);
      repeat (300) @(negedge clk);
      chk("R11 no irq after abort", irq_count, base);
      rd(2'd2, d); chk("R11 data kept after abort", d, exp_data);
      chk("R6 clock idles after abort", sck_out, 1'b1);
      m_active = 1'b0;
   endtask

   task automatic t_abort_sweep();
      logic [15:0] d;
      logic [15:0] w;
      int base, n_abort, n_done;
      n_abort = 0; n_done = 0;
      for (int off = 0; off < 6; off++) begin
         w = 16'h0030 + 16'(off * 17);
         sck_in = 1'b1;
         wr(2'd0, ctl(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1));
         repeat (4) @(negedge clk);
         base = irq_count;
         wr(2'd0, ctl(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1));
         for (int k = 0; k < 7; k++) slave_bit(w[7 - k], 1'b1, 6);
         @(negedge clk);
         sin = w[0]; sck_in = 1'b0;
         repeat (6) @(negedge clk);
         sck_in = 1'b1;
         repeat (off) @(negedge clk);
         reg_wr = 1'b1; reg_addr = 2'd0;
         reg_wdata = ctl(1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1);
         @(negedge clk);
         reg_wr = 1'b0;
         repeat (6) @(negedge clk);
         rd(2'd0, d); chk("R11 start clear after race", d[0], 1'b0);
         rd(2'd2, d);
         if (irq_count == base + 1) begin
            n_done++;
            chk("R3 R11 completed race commits word", d, {8'h0, w[7:0]});
            exp_data = {8'h0, w[7:0]};
         end else begin
            n_abort++;
            chk("R11 aborted race keeps word and no irq", {d, 16'(irq_count - base)}, {exp_data, 16'h0});
         end
      end
      chk("R11 sweep saw an abort", n_abort > 0, 1'b1);
      chk("R11 sweep saw a completion", n_done > 0, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_gate();
      t_master("m8 msb t0", 1'b0, 1'b0, 1'b0, 16'hA7B5, 8'd3);
      t_master("m16 lsb t1", 1'b1, 1'b1, 1'b1, 16'hC35A, 8'd1);
      t_master("m16 msb t0", 1'b1, 1'b0, 1'b0, 16'h8001, 8'd0);
      t_slave("s16 msb t0", 1'b1, 1'b0, 1'b0, 16'h1E2D);
      t_slave("s8 lsb t1", 1'b0, 1'b1, 1'b1, 16'hFF96);
      t_busy_lock();
      t_abort_master();
      t_abort_sweep();
      finish_run();
   end

endmodule